// File: doc/BRIEF.md
# Software-Configured Stream Routing Crossbar

This block connects N_IN incoming streams to N_OUT outgoing streams through a static routing table. Each outgoing stream has its own 32-bit selector register in a small AXI4-Lite style register space. A selector either names the incoming stream that feeds that output or switches the output off. Register writes go into a shadow copy of the table and do not change the routing yet. A write of the apply bit in the control word then moves the whole shadow table into the live table in a single cycle.

Each apply starts a short quiet window. During that window every stream handshake is forced idle, so no transfer can straddle the change of routes. Paths are strictly one-to-one. When several outputs name the same input, the output with the lowest index keeps the connection and the rest act as switched off. On a live path, TVALID, TDATA and TLAST travel from the input to the output and TREADY travels back. An input that no output owns sees TREADY low.

Top module: `stream_xbar`

## Requirements
- R1: After reset, every selector reads 0x8000_0000, the control word reads 0, all outputs have TVALID low and TDATA zero, and all inputs have TREADY low.
- R2: The selector for output i sits at byte offset 0x40 + 4*i. A read of it returns the full 32-bit value last written there.
- R3: Selector writes leave the live routing unchanged until bit 1 of the control word at offset 0x0 is written as 1. At that point all selectors take effect together.
- R4: A selector with bit 31 set turns its output off: TVALID low, TDATA and TLAST zero, and no TREADY passed to any input.
- R5: A selector with bit 31 clear whose bits 30:0 are N_IN or larger also turns its output off.
- R6: On a live path, the output carries the selected input's TVALID, TDATA and TLAST, and that input's TREADY equals the output's TREADY.
- R7: When several outputs select the same input, only the lowest-numbered of them is connected. The others are off.
- R8: An input that no connected output selects sees TREADY low.
- R9: After an apply, all outputs hold TVALID low and all inputs hold TREADY low for exactly HOLD_CYC cycles. During that time bit 1 of the control word reads 1, and it reads 0 afterwards.
- R10: Reads from any offset other than the control word and the selectors return 0. Writes to such offsets change no selector. Every write and read response is OKAY (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_awaddr | input | ADDR_W | Write byte address |
| cfg_awvalid | input | 1 | Write address valid |
| cfg_awready | output | 1 | Write address accepted |
| cfg_wdata | input | 32 | Write data |
| cfg_wvalid | input | 1 | Write data valid |
| cfg_wready | output | 1 | Write data accepted |
| cfg_bresp | output | 2 | Write response, always OKAY |
| cfg_bvalid | output | 1 | Write response valid |
| cfg_bready | input | 1 | Write response taken |
| cfg_araddr | input | ADDR_W | Read byte address |
| cfg_arvalid | input | 1 | Read address valid |
| cfg_arready | output | 1 | Read address accepted |
| cfg_rdata | output | 32 | Read data |
| cfg_rresp | output | 2 | Read response, always OKAY |
| cfg_rvalid | output | 1 | Read data valid |
| cfg_rready | input | 1 | Read data taken |
| in_tvalid | input | N_IN | Per-input TVALID |
| in_tready | output | N_IN | Per-input TREADY |
| in_tdata | input | N_IN*DATA_W | Per-input TDATA, input j at bits j*DATA_W upward |
| in_tlast | input | N_IN | Per-input TLAST |
| out_tvalid | output | N_OUT | Per-output TVALID |
| out_tready | input | N_OUT | Per-output TREADY |
| out_tdata | output | N_OUT*DATA_W | Per-output TDATA, output i at bits i*DATA_W upward |
| out_tlast | output | N_OUT | Per-output TLAST |

## Verification
The bench runs a three-by-three instance. It programs every table built from the selector values {0, 1, 2, 5, off}, which covers identity, permutations, shared inputs where the lowest output must win, out-of-range indices and switched-off outputs. For each table it applies all 64 combinations of input TVALID and output TREADY. These combinations separate a correct forward mux from a swapped or stuck one, and show whether TREADY is returned to the right input. Before each apply, the previous table is checked again, which catches writes leaking straight into the live routing. After each apply, the quiet window is measured cycle by cycle at the ports.

// File: rtl/sxb_pkg.sv
package sxb_pkg;
   localparam int          SXB_CTRL_OFS   = 'h00;
   localparam int          SXB_SEL_BASE   = 'h40;
   localparam int          SXB_APPLY_BIT  = 1;
   localparam int          SXB_OFF_BIT    = 31;
   localparam logic [31:0] SXB_SEL_OFF    = 32'h8000_0000;
   localparam logic [1:0]  SXB_RESP_OKAY  = 2'b00;
endpackage

// File: rtl/sxb_regs.sv
module sxb_regs
   import sxb_pkg::*;
#(
   parameter int N_IN     = 4,
   parameter int N_OUT    = 4,
   parameter int ADDR_W   = 8,
   parameter int SEL_W    = 2,
   parameter int HOLD_CYC = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [ADDR_W-1:0]            awaddr,
   input  logic                         awvalid,
   output logic                         awready,
   input  logic [31:0]                  wdata,
   input  logic                         wvalid,
   output logic                         wready,
   output logic                         bvalid,
   input  logic                         bready,
   input  logic [ADDR_W-1:0]            araddr,
   input  logic                         arvalid,
   output logic                         arready,
   output logic [31:0]                  rdata,
   output logic                         rvalid,
   input  logic                         rready,
   output logic [N_OUT-1:0]             act_en,
   output logic [N_OUT-1:0][SEL_W-1:0]  act_sel,
   output logic                         apply,
   output logic                         busy
);
   localparam int CNT_W = $clog2(HOLD_CYC + 1);

   logic [N_OUT-1:0][31:0] shadow_q;
   logic [CNT_W-1:0]       hold_q;
   logic                   wr_go, rd_go;
   logic [31:0]            rd_val;

   assign wr_go   = awvalid && wvalid && !bvalid;
   assign awready = wr_go;
   assign wready  = wr_go;
   assign rd_go   = arvalid && !rvalid;
   assign arready = rd_go;
   assign apply   = wr_go && (awaddr == ADDR_W'(SXB_CTRL_OFS)) && wdata[SXB_APPLY_BIT];
   assign busy    = (hold_q != '0);

   always_comb begin
      rd_val = '0;
      if (araddr == ADDR_W'(SXB_CTRL_OFS)) rd_val[SXB_APPLY_BIT] = busy;
      for (int o = 0; o < N_OUT; o++)
         if (araddr == ADDR_W'(SXB_SEL_BASE + 4 * o)) rd_val = shadow_q[o];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_q <= {N_OUT{SXB_SEL_OFF}};
         act_en   <= '0;
         act_sel  <= '0;
         hold_q   <= '0;
         bvalid   <= 1'b0;
         rvalid   <= 1'b0;
         rdata    <= '0;
      end else begin
         for (int o = 0; o < N_OUT; o++)
            if (wr_go && awaddr == ADDR_W'(SXB_SEL_BASE + 4 * o)) shadow_q[o] <= wdata;
         if (apply) begin
            for (int o = 0; o < N_OUT; o++) begin
               act_en[o]  <= !shadow_q[o][SXB_OFF_BIT] && (shadow_q[o][30:0] < 31'(N_IN));
               act_sel[o] <= shadow_q[o][SEL_W-1:0];
            end
            hold_q <= CNT_W'(HOLD_CYC);
         end else if (busy) begin
            hold_q <= hold_q - 1'b1;
         end
         if (wr_go)       bvalid <= 1'b1;
         else if (bready) bvalid <= 1'b0;
         if (rd_go) begin
            rvalid <= 1'b1;
            rdata  <= rd_val;
         end else if (rready) begin
            rvalid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/sxb_resolve.sv
module sxb_resolve #(
   parameter int N_OUT = 4,
   parameter int SEL_W = 2
) (
   input  logic [N_OUT-1:0]            act_en,
   input  logic [N_OUT-1:0][SEL_W-1:0] act_sel,
   output logic [N_OUT-1:0]            conn
);
   always_comb begin
      for (int o = 0; o < N_OUT; o++) begin
         conn[o] = act_en[o];
         for (int p = 0; p < N_OUT; p++)
            if (p < o && act_en[p] && act_sel[p] == act_sel[o]) conn[o] = 1'b0;
      end
   end
endmodule

// File: rtl/sxb_fabric.sv
module sxb_fabric #(
   parameter int N_IN   = 4,
   parameter int N_OUT  = 4,
   parameter int DATA_W = 32,
   parameter int SEL_W  = 2
) (
   input  logic                          busy,
   input  logic [N_OUT-1:0]              conn,
   input  logic [N_OUT-1:0][SEL_W-1:0]   act_sel,
   input  logic [N_IN-1:0]               s_tvalid,
   output logic [N_IN-1:0]               s_tready,
   input  logic [N_IN-1:0][DATA_W-1:0]   s_tdata,
   input  logic [N_IN-1:0]               s_tlast,
   output logic [N_OUT-1:0]              m_tvalid,
   input  logic [N_OUT-1:0]              m_tready,
   output logic [N_OUT-1:0][DATA_W-1:0]  m_tdata,
   output logic [N_OUT-1:0]              m_tlast
);
   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic [SEL_W-1:0] src;
      assign src         = act_sel[o];
      assign m_tvalid[o] = !busy && conn[o] && s_tvalid[src];
      assign m_tdata[o]  = conn[o] ? s_tdata[src] : '0;
      assign m_tlast[o]  = conn[o] && s_tlast[src];
   end

   always_comb begin
      s_tready = '0;
      for (int i = 0; i < N_IN; i++)
         for (int o = 0; o < N_OUT; o++)
            if (!busy && conn[o] && act_sel[o] == SEL_W'(i) && m_tready[o]) s_tready[i] = 1'b1;
   end
endmodule

// File: rtl/stream_xbar.sv
module stream_xbar
   import sxb_pkg::*;
#(
   parameter int N_IN     = 4,
   parameter int N_OUT    = 4,
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 8,
   parameter int HOLD_CYC = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         cfg_awaddr,
   input  logic                      cfg_awvalid,
   output logic                      cfg_awready,
   input  logic [31:0]               cfg_wdata,
   input  logic                      cfg_wvalid,
   output logic                      cfg_wready,
   output logic [1:0]                cfg_bresp,
   output logic                      cfg_bvalid,
   input  logic                      cfg_bready,
   input  logic [ADDR_W-1:0]         cfg_araddr,
   input  logic                      cfg_arvalid,
   output logic                      cfg_arready,
   output logic [31:0]               cfg_rdata,
   output logic [1:0]                cfg_rresp,
   output logic                      cfg_rvalid,
   input  logic                      cfg_rready,
   input  logic [N_IN-1:0]           in_tvalid,
   output logic [N_IN-1:0]           in_tready,
   input  logic [N_IN*DATA_W-1:0]    in_tdata,
   input  logic [N_IN-1:0]           in_tlast,
   output logic [N_OUT-1:0]          out_tvalid,
   input  logic [N_OUT-1:0]          out_tready,
   output logic [N_OUT*DATA_W-1:0]   out_tdata,
   output logic [N_OUT-1:0]          out_tlast
);
   localparam int SEL_W = (N_IN > 1) ? $clog2(N_IN) : 1;

   if (N_IN < 1 || N_OUT < 1) begin : g_bad_ports
      $error("stream_xbar: N_IN and N_OUT must be at least 1");
   end
   if (SXB_SEL_BASE + 4 * N_OUT > (1 << ADDR_W)) begin : g_bad_addr
      $error("stream_xbar: ADDR_W too narrow for N_OUT selectors");
   end
   if (HOLD_CYC < 1) begin : g_bad_hold
      $error("stream_xbar: HOLD_CYC must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("stream_xbar: DATA_W must be at least 1");
   end

   logic [N_OUT-1:0]             act_en;
   logic [N_OUT-1:0][SEL_W-1:0]  act_sel;
   logic [N_OUT-1:0]             conn;
   logic                         apply;
   logic                         hold_busy;
   logic [N_IN-1:0][DATA_W-1:0]  in_data_v;
   logic [N_OUT-1:0][DATA_W-1:0] out_data_v;

   assign in_data_v = in_tdata;
   assign out_tdata = out_data_v;
   assign cfg_bresp = SXB_RESP_OKAY;
   assign cfg_rresp = SXB_RESP_OKAY;

   sxb_regs #(.N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .HOLD_CYC(HOLD_CYC)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .awaddr(cfg_awaddr), .awvalid(cfg_awvalid), .awready(cfg_awready),
      .wdata(cfg_wdata), .wvalid(cfg_wvalid), .wready(cfg_wready),
      .bvalid(cfg_bvalid), .bready(cfg_bready),
      .araddr(cfg_araddr), .arvalid(cfg_arvalid), .arready(cfg_arready),
      .rdata(cfg_rdata), .rvalid(cfg_rvalid), .rready(cfg_rready),
      .act_en(act_en), .act_sel(act_sel), .apply(apply), .busy(hold_busy)
   );

   sxb_resolve #(.N_OUT(N_OUT), .SEL_W(SEL_W)) u_resolve (
      .act_en(act_en), .act_sel(act_sel), .conn(conn)
   );

   sxb_fabric #(.N_IN(N_IN), .N_OUT(N_OUT), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_fabric (
      .busy(hold_busy), .conn(conn), .act_sel(act_sel),
      .s_tvalid(in_tvalid), .s_tready(in_tready), .s_tdata(in_data_v), .s_tlast(in_tlast),
      .m_tvalid(out_tvalid), .m_tready(out_tready), .m_tdata(out_data_v), .m_tlast(out_tlast)
   );
endmodule

// File: rtl/sxb_chk.sv
module sxb_chk #(
   parameter int N_IN     = 4,
   parameter int N_OUT    = 4,
   parameter int SEL_W    = 2,
   parameter int HOLD_CYC = 4
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         busy,
   input logic                         apply,
   input logic [N_OUT-1:0]             act_en,
   input logic [N_OUT-1:0][SEL_W-1:0]  act_sel,
   input logic [N_OUT-1:0]             conn,
   input logic [N_OUT-1:0]             m_tvalid,
   input logic [N_IN-1:0]              s_tready,
   input logic                         bvalid,
   input logic                         bready
);
   logic [31:0] run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     run_q <= '0;
      else if (apply) run_q <= 32'd1;
      else if (busy)  run_q <= run_q + 32'd1;
      else            run_q <= '0;
   end

   // R9
   quiet_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (m_tvalid == '0 && s_tready == '0));

   // R9
   quiet_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_q <= 32'(HOLD_CYC));

   // R3
   live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(apply) |-> ($stable(act_en) && $stable(act_sel)));

   // R10
   resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bvalid && !bready) |=> bvalid);

   for (genvar o = 0; o < N_OUT; o++) begin : g_o
      // R4
      off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !act_en[o] |-> !m_tvalid[o]);
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_i
      logic [N_OUT-1:0] owners;
      always_comb
         for (int o = 0; o < N_OUT; o++)
            owners[o] = conn[o] && act_sel[o] == SEL_W'(i);
      // R7
      one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $onehot0(owners));
   end
endmodule

bind stream_xbar sxb_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .HOLD_CYC(HOLD_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(hold_busy), .apply(apply),
   .act_en(act_en), .act_sel(act_sel), .conn(conn),
   .m_tvalid(out_tvalid), .s_tready(in_tready),
   .bvalid(cfg_bvalid), .bready(cfg_bready)
);

// File: tb/tb_stream_xbar.sv
module tb_stream_xbar;
   localparam int CLK_PERIOD = 10;
   localparam int NI = 3;
   localparam int NO = 3;
   localparam int DW = 8;
   localparam int AW = 8;
   localparam int HOLD = 4;

   logic clk = 0, rst_n = 0;
   logic [AW-1:0] awaddr = 0, araddr = 0;
   logic awvalid = 0, wvalid = 0, arvalid = 0, bready = 1, rready = 1;
   logic [31:0] wdata = 0;
   logic awready, wready, bvalid, arready, rvalid;
   logic [1:0] bresp, rresp;
   logic [31:0] rdata;
   logic [NI-1:0] in_tvalid = 0, in_tlast = 0, in_tready;
   logic [NI*DW-1:0] in_tdata = 0;
   logic [NO-1:0] out_tvalid, out_tlast, out_tready = 0;
   logic [NO*DW-1:0] out_tdata;

   int n_chk = 0, n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stream_xbar #(.N_IN(NI), .N_OUT(NO), .DATA_W(DW), .ADDR_W(AW), .HOLD_CYC(HOLD)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_awaddr(awaddr), .cfg_awvalid(awvalid), .cfg_awready(awready),
      .cfg_wdata(wdata), .cfg_wvalid(wvalid), .cfg_wready(wready),
      .cfg_bresp(bresp), .cfg_bvalid(bvalid), .cfg_bready(bready),
      .cfg_araddr(araddr), .cfg_arvalid(arvalid), .cfg_arready(arready),
      .cfg_rdata(rdata), .cfg_rresp(rresp), .cfg_rvalid(rvalid), .cfg_rready(rready),
      .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tdata(in_tdata), .in_tlast(in_tlast),
      .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tdata(out_tdata), .out_tlast(out_tlast)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
      #1;
      while (!awready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      awvalid = 0; wvalid = 0;
      chk("R10 bresp", {30'b0, bresp}, 0);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      araddr = a; arvalid = 1;
      #1;
      while (!arready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      arvalid = 0;
      d = rdata;
      chk("R10 rresp", {30'b0, rresp}, 0);
   endtask

   // Model of routing; force_tag overrides the requirement tag (used for R3/R1)
   task automatic check_paths(input logic [31:0] c [NO], input string force_tag);
      logic en [NO];
      logic cn [NO];
      logic [1:0] s [NO];
      string tg;
      for (int o = 0; o < NO; o++) begin
         en[o] = !c[o][31] && (c[o][30:0] < 31'(NI));
         s[o]  = c[o][1:0];
      end
      for (int o = 0; o < NO; o++) begin
         cn[o] = en[o];
         for (int p = 0; p < o; p++) if (en[p] && s[p] == s[o]) cn[o] = 0;
      end
      for (int tv = 0; tv < 8; tv++) begin
         for (int tr = 0; tr < 8; tr++) begin
            in_tvalid = 3'(tv);
            out_tready = 3'(tr);
            in_tlast = ~3'(tv);
            for (int i = 0; i < NI; i++) in_tdata[i*DW +: DW] = 8'(i * 37 + tv * 5 + tr + 1);
            #1;
            for (int o = 0; o < NO; o++) begin
               logic ev, el;
               logic [7:0] ed;
               if (force_tag != "") tg = force_tag;
               else if (c[o][31]) tg = "R4";
               else if (!en[o]) tg = "R5";
               else if (!cn[o]) tg = "R7";
               else tg = "R6";
               ev = cn[o] ? in_tvalid[s[o]] : 1'b0;
               ed = cn[o] ? in_tdata[s[o]*DW +: DW] : 8'h00;
               el = cn[o] ? in_tlast[s[o]] : 1'b0;
               chk({tg, " tvalid"}, {31'b0, out_tvalid[o]}, {31'b0, ev});
               chk({tg, " tdata"}, {24'b0, out_tdata[o*DW +: DW]}, {24'b0, ed});
               chk({tg, " tlast"}, {31'b0, out_tlast[o]}, {31'b0, el});
            end
            for (int i = 0; i < NI; i++) begin
               logic er, owned;
               er = 0; owned = 0;
               for (int o = 0; o < NO; o++)
                  if (cn[o] && s[o] == 2'(i)) begin owned = 1; er = out_tready[o]; end
               tg = (force_tag != "") ? force_tag : (owned ? "R6" : "R8");
               chk({tg, " tready"}, {31'b0, in_tready[i]}, {31'b0, er});
            end
         end
      end
   endtask

   task automatic apply_and_measure(input logic [31:0] c [NO]);
      int quiet;
      logic any;
      any = 0;
      for (int o = 0; o < NO; o++) if (!c[o][31] && c[o][30:0] < 31'(NI)) any = 1;
      in_tvalid = '1; out_tready = '1;
      wr(8'h00, 32'h2);
      quiet = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); #1;
         if (out_tvalid == '0 && in_tready == '0) quiet++;
      end
      chk("R9 quiet cycles", quiet, any ? HOLD : 8);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      logic [31:0] vals [5];
      logic [31:0] cur [NO];
      logic [31:0] prev [NO];
      vals[0] = 0; vals[1] = 1; vals[2] = 2; vals[3] = 5; vals[4] = 32'h8000_0000;

      repeat (3) @(posedge clk);
      rst_n = 1;

      // R1 reset state
      for (int o = 0; o < NO; o++) begin
         rd(8'(8'h40 + 4 * o), d);
         chk("R1 selector reset", d, 32'h8000_0000);
         prev[o] = 32'h8000_0000;
      end
      rd(8'h00, d);
      chk("R1 control reset", d, 0);
      check_paths(prev, "R1");

      // R10 unmapped reads and writes
      rd(8'h20, d); chk("R10 unmapped read 0x20", d, 0);
      rd(8'h4C, d); chk("R10 unmapped read 0x4C", d, 0);
      rd(8'h41, d); chk("R10 unmapped read 0x41", d, 0);
      wr(8'h4C, 32'h0000_0001);
      wr(8'h45, 32'h0000_0002);
      wr(8'h04, 32'h0000_0002);
      for (int o = 0; o < NO; o++) begin
         rd(8'(8'h40 + 4 * o), d);
         chk("R10 write ignored", d, 32'h8000_0000);
      end
      rd(8'h00, d);
      chk("R10 stray write no apply", d, 0);

      // R9 busy bit readback
      wr(8'h40, 0);
      wr(8'h00, 32'h2);
      rd(8'h00, d);
      chk("R9 busy reads 1", d, 32'h2);
      repeat (6) @(posedge clk);
      rd(8'h00, d);
      chk("R9 busy clears", d, 0);
      prev[0] = 0;
      check_paths(prev, "");

      // Sweep every table from vals
      for (int cfg = 0; cfg < 125; cfg++) begin
         cur[0] = vals[cfg % 5];
         cur[1] = vals[(cfg / 5) % 5];
         cur[2] = vals[(cfg / 25) % 5];
         for (int o = 0; o < NO; o++) wr(8'(8'h40 + 4 * o), cur[o]);
         check_paths(prev, "R3");
         for (int o = 0; o < NO; o++) begin
            rd(8'(8'h40 + 4 * o), d);
            chk("R2 selector readback", d, cur[o]);
         end
         apply_and_measure(cur);
         check_paths(cur, "");
         for (int o = 0; o < NO; o++) prev[o] = cur[o];
      end

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule